// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Threshold

This block is a watchdog peripheral with two clock domains. Software sees a small register file on the bus clock through a single-cycle write strobe and a combinational read port. The countdown runs on a separate slow clock, usually a 32.768 kHz source, where one second of timeout is 32768 counter steps. Software loads a 32-bit expiry value and a 32-bit early-warning value, each as two 16-bit halves. Once started, the counter steps down by one per slow-clock period. It raises an interrupt flag when it reaches the early-warning value and a reset flag when it reaches zero.

Every register except the lock register ignores writes until the unlock key is written. A new load crosses into the slow domain through a toggle handshake, and a busy flag stays up until the slow domain has accepted it. The running count comes back to the bus domain as a snapshot, taken by a second handshake, so the two 16-bit halves always belong to the same count value. Rewriting the expiry value restarts the countdown, which is how software services the watchdog.

Top module: `wdt_lock_timer`

## Requirements
- R1: After reset the block is locked. The control register, both raw flags, `irq` and `rst_req` are all zero.
- R2: Writing 0x0000E551 to the lock register (offset 0x20) unlocks the block. Writing any other value locks it. Reading the lock register returns 1 in bit 0 while the block is locked.
- R3: While the block is locked, writes to every register other than the lock register have no effect. Reads work in both states.
- R4: Each 32-bit value is held as two 16-bit halves, with the upper half at the higher offset. The expiry load uses 0x04 (upper) and 0x00 (lower). The early-warning load uses 0x30 (upper) and 0x2C (lower). The count readback uses 0x1C (upper, bits 31:16) and 0x18 (lower, bits 15:0).
- R5: A write to the expiry-low register (0x00) commits both load values, and the counter reloads from the expiry value. Raw status bit 4 (busy) reads 1 on the next bus cycle and returns to 0 within five slow-clock periods.
- R6: A write to the expiry-low register while busy is set is dropped. Both the register and the counter keep the earlier value.
- R7: The counter steps down by one per slow-clock period while control bit 1 (run) is set. It holds its value while run is clear, and it stays at zero once it gets there.
- R8: When control bit 2 (warning mode) is set, raw bit 0 sets when the count steps down onto the early-warning value. When warning mode is clear, raw bit 0 sets when the count reaches zero.
- R9: Raw bit 3 sets when the count steps down onto zero.
- R10: Writing the clear register (offset 0x0C) clears raw bit 0 when data bit 0 is 1 and clears raw bit 3 when data bit 3 is 1. A flag whose data bit is 0 is left unchanged.
- R11: `irq` is high exactly when raw bit 0 is set, control bit 0 (interrupt enable) is set, and mask bit 0 (offset 0x14) is clear.
- R12: `rst_req` is high exactly when raw bit 3 is set and control bit 3 (reset enable) is set.
- R13: With the counter held, the count readback returns exactly the value that was loaded, with both halves from the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| slow_clk | input | 1 | Slow counting clock |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The bench aims at the ordering of the early-warning flag before the expiry flag. A design that compared against the wrong register, or that fired on the reload value, would raise the interrupt at the wrong time or together with the reset. It sends a second commit while busy is set. A design without the busy guard would overwrite the load shadow during the crossing, and the snapshot would show the second value. Random values are loaded with the counter held and read back as halves, which exposes a swapped or torn split. Random non-key lock writes followed by control writes show whether the lock actually drops those writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_TMR_LO = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_TMR_HI = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_PRE_LO = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_PRE_HI = 6'h30;

  localparam int RAW_IRQ  = 0;
  localparam int RAW_RST  = 3;
  localparam int RAW_BUSY = 4;

  localparam logic [15:0] UNLOCK_KEY = 16'hE551;

  // control word, bit3 down to bit0
  typedef struct packed {
    logic rst_en;
    logic pre_mode;
    logic run;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_mode,
  input  logic             load_req,
  input  logic [CNT_W-1:0] tmr_load,
  input  logic [CNT_W-1:0] pre_load,
  input  logic             snap_ack,
  output logic             load_ack,
  output logic             int_tgl,
  output logic             rst_tgl,
  output logic             snap_tgl,
  output logic [CNT_W-1:0] snap_data
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             seen_q, seen_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic             int_q, int_d, rst_q, rst_d;
  logic             snap_q, snap_d;
  logic [CNT_W-1:0] sdata_q, sdata_d;
  logic             load_pulse, step, last, hit_pre, free;

  always_comb begin
    load_pulse = load_req ^ seen_q;
    seen_d     = load_req;
    step       = run & ~load_pulse & (count_q != '0);
    last       = (count_q == ONE);
    hit_pre    = pre_mode ? ((count_q - ONE) == pre_q) : last;
    count_d    = load_pulse ? tmr_load : (step ? count_q - ONE : count_q);
    pre_d      = load_pulse ? pre_load : pre_q;
    int_d      = int_q ^ (step & hit_pre);
    rst_d      = rst_q ^ (step & last);
    free       = (snap_ack == snap_q);
    snap_d     = free ? ~snap_q : snap_q;
    sdata_d    = free ? count_q : sdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      count_q <= '0;
      pre_q   <= '0;
      int_q   <= 1'b0;
      rst_q   <= 1'b0;
      snap_q  <= 1'b0;
      sdata_q <= '0;
    end else begin
      seen_q  <= seen_d;
      count_q <= count_d;
      pre_q   <= pre_d;
      int_q   <= int_d;
      rst_q   <= rst_d;
      snap_q  <= snap_d;
      sdata_q <= sdata_d;
    end
  end

  assign load_ack  = seen_q;
  assign int_tgl   = int_q;
  assign rst_tgl   = rst_q;
  assign snap_tgl  = snap_q;
  assign snap_data = sdata_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              load_req_tgl,
  input  logic              load_ack_tgl,
  output logic [CNT_W-1:0]  tmr_load,
  output logic [CNT_W-1:0]  pre_load,
  output ctrl_t             ctrl,
  input  logic              int_tgl,
  input  logic              rst_tgl,
  input  logic              snap_tgl,
  input  logic [CNT_W-1:0]  snap_data,
  output logic              snap_ack_tgl,
  output logic              irq,
  output logic              rst_req
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(UNLOCK_KEY);

  logic              locked_q, locked_d;
  logic [HALF_W-1:0] tmr_hi_q, tmr_hi_d, tmr_lo_q, tmr_lo_d;
  logic [HALF_W-1:0] pre_hi_q, pre_hi_d, pre_lo_q, pre_lo_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              mask_q, mask_d;
  logic              raw_irq_q, raw_irq_d, raw_rst_q, raw_rst_d;
  logic              req_q, req_d;
  logic              int_seen_q, rst_seen_q, snap_seen_q;
  logic [CNT_W-1:0]  cnt_snap_q, cnt_snap_d;
  logic [CNT_W-1:0]  tmr_sh_q, tmr_sh_d, pre_sh_q, pre_sh_d;
  logic              wr_ok, busy, commit, clr_wr;
  logic [HALF_W-1:0] wlow;

  always_comb begin
    wr_ok  = bus_wr & ~locked_q;
    busy   = req_q ^ load_ack_tgl;
    commit = wr_ok & (bus_addr == OFF_TMR_LO) & ~busy;
    clr_wr = wr_ok & (bus_addr == OFF_CLR);
    wlow   = bus_wdata[HALF_W-1:0];

    locked_d   = locked_q;
    tmr_hi_d   = tmr_hi_q;
    tmr_lo_d   = tmr_lo_q;
    pre_hi_d   = pre_hi_q;
    pre_lo_d   = pre_lo_q;
    ctrl_d     = ctrl_q;
    mask_d     = mask_q;
    req_d      = req_q;
    tmr_sh_d   = tmr_sh_q;
    pre_sh_d   = pre_sh_q;

    if (bus_wr && bus_addr == OFF_LOCK) locked_d = (bus_wdata != KEY_WORD);
    if (wr_ok) begin
      unique case (bus_addr)
        OFF_TMR_HI: tmr_hi_d = wlow;
        OFF_PRE_HI: pre_hi_d = wlow;
        OFF_PRE_LO: pre_lo_d = wlow;
        OFF_CTRL:   ctrl_d   = ctrl_t'(bus_wdata[3:0]);
        OFF_MASK:   mask_d   = bus_wdata[0];
        default: ;
      endcase
    end
    if (commit) begin
      tmr_lo_d = wlow;
      tmr_sh_d = {tmr_hi_q, wlow};
      pre_sh_d = {pre_hi_q, pre_lo_q};
      req_d    = ~req_q;
    end

    raw_irq_d  = (int_tgl ^ int_seen_q) |
                 (raw_irq_q & ~(clr_wr & bus_wdata[RAW_IRQ]));
    raw_rst_d  = (rst_tgl ^ rst_seen_q) |
                 (raw_rst_q & ~(clr_wr & bus_wdata[RAW_RST]));
    cnt_snap_d = (snap_tgl ^ snap_seen_q) ? snap_data : cnt_snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q    <= 1'b1;
      tmr_hi_q    <= '0;
      tmr_lo_q    <= '0;
      pre_hi_q    <= '0;
      pre_lo_q    <= '0;
      ctrl_q      <= '0;
      mask_q      <= 1'b0;
      raw_irq_q   <= 1'b0;
      raw_rst_q   <= 1'b0;
      req_q       <= 1'b0;
      int_seen_q  <= 1'b0;
      rst_seen_q  <= 1'b0;
      snap_seen_q <= 1'b0;
      cnt_snap_q  <= '0;
      tmr_sh_q    <= '0;
      pre_sh_q    <= '0;
    end else begin
      locked_q    <= locked_d;
      tmr_hi_q    <= tmr_hi_d;
      tmr_lo_q    <= tmr_lo_d;
      pre_hi_q    <= pre_hi_d;
      pre_lo_q    <= pre_lo_d;
      ctrl_q      <= ctrl_d;
      mask_q      <= mask_d;
      raw_irq_q   <= raw_irq_d;
      raw_rst_q   <= raw_rst_d;
      req_q       <= req_d;
      int_seen_q  <= int_tgl;
      rst_seen_q  <= rst_tgl;
      snap_seen_q <= snap_tgl;
      cnt_snap_q  <= cnt_snap_d;
      tmr_sh_q    <= tmr_sh_d;
      pre_sh_q    <= pre_sh_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_TMR_LO: bus_rdata = DATA_W'(tmr_lo_q);
      OFF_TMR_HI: bus_rdata = DATA_W'(tmr_hi_q);
      OFF_PRE_LO: bus_rdata = DATA_W'(pre_lo_q);
      OFF_PRE_HI: bus_rdata = DATA_W'(pre_hi_q);
      OFF_CTRL:   bus_rdata = DATA_W'(ctrl_q);
      OFF_MASK:   bus_rdata = DATA_W'(mask_q);
      OFF_CNT_LO: bus_rdata = DATA_W'(cnt_snap_q[HALF_W-1:0]);
      OFF_CNT_HI: bus_rdata = DATA_W'(cnt_snap_q[CNT_W-1:HALF_W]);
      OFF_LOCK:   bus_rdata = DATA_W'(locked_q);
      OFF_RAW: begin
        bus_rdata[RAW_IRQ]  = raw_irq_q;
        bus_rdata[RAW_RST]  = raw_rst_q;
        bus_rdata[RAW_BUSY] = busy;
      end
      default: ;
    endcase
  end

  assign load_req_tgl = req_q;
  assign snap_ack_tgl = snap_seen_q;
  assign tmr_load     = tmr_sh_q;
  assign pre_load     = pre_sh_q;
  assign ctrl         = ctrl_q;
  assign irq          = raw_irq_q & ctrl_q.irq_en & ~mask_q;
  assign rst_req      = raw_rst_q & ctrl_q.rst_en;
endmodule

// File: rtl/wdt_lock_timer.sv
module wdt_lock_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int XW = 4;

  logic             rst_b_n, rst_s_n;
  ctrl_t            ctrl;
  logic             load_req_tgl, snap_ack_tgl;
  logic             load_ack_s, int_tgl_s, rst_tgl_s, snap_tgl_s;
  logic [XW-1:0]    to_slow, at_slow, to_bus, at_bus;
  logic [CNT_W-1:0] tmr_load, pre_load, snap_data;

  wdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_b (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_b_n));
  wdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_s (
    .clk(slow_clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  assign to_slow = {load_req_tgl, ctrl.run, ctrl.pre_mode, snap_ack_tgl};
  wdt_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_b2s (
    .clk(slow_clk), .rst_n(rst_s_n), .d(to_slow), .q(at_slow));

  assign to_bus = {load_ack_s, int_tgl_s, rst_tgl_s, snap_tgl_s};
  wdt_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_s2b (
    .clk(clk), .rst_n(rst_b_n), .d(to_bus), .q(at_bus));

  wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_b_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .load_req_tgl(load_req_tgl), .load_ack_tgl(at_bus[3]),
    .tmr_load(tmr_load), .pre_load(pre_load), .ctrl(ctrl),
    .int_tgl(at_bus[2]), .rst_tgl(at_bus[1]), .snap_tgl(at_bus[0]),
    .snap_data(snap_data), .snap_ack_tgl(snap_ack_tgl),
    .irq(irq), .rst_req(rst_req));

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(slow_clk), .rst_n(rst_s_n),
    .run(at_slow[2]), .pre_mode(at_slow[1]), .load_req(at_slow[3]),
    .tmr_load(tmr_load), .pre_load(pre_load), .snap_ack(at_slow[0]),
    .load_ack(load_ack_s), .int_tgl(int_tgl_s), .rst_tgl(rst_tgl_s),
    .snap_tgl(snap_tgl_s), .snap_data(snap_data));
endmodule

// File: rtl/wdt_lock_timer_chk.sv
module wdt_lock_timer_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_b_n,
  input logic              slow_clk,
  input logic              rst_s_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              locked,
  input logic              req_tgl,
  input logic              ack_tgl,
  input logic [3:0]        ctrl_bits,
  input logic [CNT_W/2-1:0] tmr_lo,
  input logic              raw_irq,
  input logic              load_now,
  input logic [CNT_W-1:0]  count
);
  logic busy;
  assign busy = req_tgl ^ ack_tgl;

  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_b_n)
    (bus_wr && locked && bus_addr == OFF_CTRL) |=> $stable(ctrl_bits));

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_b_n)
    (bus_wr && bus_addr == OFF_LOCK && bus_wdata == DATA_W'(UNLOCK_KEY)) |=> !locked);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_b_n)
    (bus_wr && busy && bus_addr == OFF_TMR_LO) |=> $stable(tmr_lo));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_b_n)
    $rose(busy) |-> $past(bus_wr && !locked && bus_addr == OFF_TMR_LO));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_b_n)
    $fell(raw_irq) |-> $past(bus_wr && !locked && bus_addr == OFF_CLR && bus_wdata[RAW_IRQ]));

  assert_no_count_up_R7: assert property (@(posedge slow_clk) disable iff (!rst_s_n)
    !load_now |=> count <= $past(count));
endmodule

bind wdt_lock_timer wdt_lock_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_b_n(rst_b_n), .slow_clk(slow_clk), .rst_s_n(rst_s_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .locked(u_regs.locked_q), .req_tgl(load_req_tgl), .ack_tgl(at_bus[3]),
  .ctrl_bits(u_regs.ctrl_q), .tmr_lo(u_regs.tmr_lo_q),
  .raw_irq(u_regs.raw_irq_q), .load_now(u_cnt.load_pulse),
  .count(u_cnt.count_q));

// File: tb/wdt_lock_timer_tb.sv
module wdt_lock_timer_tb_top;
  localparam int SLOW_DIV = 8;

  logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int checks = 0, fails = 0;
  logic [31:0] rd, rd2;
  int unsigned seed;

  always #10 clk = ~clk;
  always #80 slow_clk = ~slow_clk;

  wdt_lock_timer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  function automatic logic exp_irq(logic raw0, logic en, logic msk);
    return raw0 & en & ~msk;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, logic [31:0] act, logic [31:0] lo, logic [31:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdr(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic wait_slow(int n);
    repeat (n * SLOW_DIV) @(posedge clk);
  endtask

  task automatic load(logic [31:0] t, logic [31:0] p);
    wr(6'h30, {16'h0, p[31:16]});
    wr(6'h2C, {16'h0, p[15:0]});
    wr(6'h04, {16'h0, t[31:16]});
    wr(6'h00, {16'h0, t[15:0]});
  endtask

  task automatic read_count(output logic [31:0] v);
    logic [31:0] h, l;
    rdr(6'h1C, h);
    rdr(6'h18, l);
    v = {h[15:0], l[15:0]};
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    wait_slow(4);

    // R1 reset state
    rdr(6'h08, rd); check("R1 ctrl", rd, 0);
    rdr(6'h10, rd); check("R1 raw", rd, 0);
    rdr(6'h20, rd); check("R1 locked", rd, 1);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);

    // R3 locked writes dropped
    wr(6'h08, 32'hF);
    rdr(6'h08, rd); check("R3 ctrl locked", rd, 0);
    wr(6'h04, 32'h1234);
    rdr(6'h04, rd); check("R3 load hi locked", rd, 0);

    // R2 key and relock
    wr(6'h20, 32'h0000E551);
    rdr(6'h20, rd); check("R2 unlocked", rd, 0);
    wr(6'h20, 32'h0);
    rdr(6'h20, rd); check("R2 relocked", rd, 1);

    // R3 random non-key relock then control write
    for (int i = 0; i < 4; i++) begin
      logic [31:0] k;
      wr(6'h20, 32'h0000E551);
      k = $urandom();
      if (k == 32'h0000E551) k = 32'h1;
      wr(6'h20, k);
      wr(6'h08, $urandom() | 32'h2);
      rdr(6'h08, rd); check("R3 random lock", rd, 0);
    end
    wr(6'h20, 32'h0000E551);

    // R4 R13 frozen loads
    for (int i = 0; i < 6; i++) begin
      logic [31:0] t;
      t = $urandom();
      if (i == 0) t = 32'hFFFF_0001;
      load(t, 32'h0);
      wait_slow(10);
      rdr(6'h04, rd); check("R4 tmr hi", rd, {16'h0, t[31:16]});
      rdr(6'h00, rd); check("R4 tmr lo", rd, {16'h0, t[15:0]});
      read_count(rd); check("R13 count snapshot", rd, t);
    end

    // R5 R6 busy and drop
    wr(6'h04, 32'h0);
    wr(6'h00, 32'h0100);
    rdr(6'h10, rd); check("R5 busy set", {31'b0, rd[4]}, 1);
    wr(6'h00, 32'h0200);
    wait_slow(6);
    rdr(6'h10, rd); check("R5 busy clear", {31'b0, rd[4]}, 0);
    rdr(6'h00, rd); check("R6 lo kept", rd, 32'h0100);
    wait_slow(6);
    read_count(rd); check("R6 count kept", rd, 32'h0100);

    // R7 run then freeze
    load(32'd1000, 32'd0);
    wait_slow(6);
    wr(6'h08, 32'h2);
    wait_slow(100);
    wr(6'h08, 32'h0);
    wait_slow(10);
    read_count(rd);
    check_rng("R7 stepped count", rd, 32'd893, 32'd905);
    wait_slow(10);
    read_count(rd2); check("R7 frozen", rd2, rd);

    // R8 R9 R11 R12 warning mode
    load(32'd60, 32'd30);
    wait_slow(6);
    wr(6'h08, 32'hF);
    wait_slow(20);
    rdr(6'h10, rd); check("R8 early no flag", {31'b0, rd[0]}, 0);
    check("R11 irq low", {31'b0, irq}, 0);
    wait_slow(20);
    rdr(6'h10, rd);
    check("R8 warning flag", {31'b0, rd[0]}, 1);
    check("R9 no expiry yet", {31'b0, rd[3]}, 0);
    check("R11 irq high", {31'b0, irq}, {31'b0, exp_irq(1'b1, 1'b1, 1'b0)});
    check("R12 rst low", {31'b0, rst_req}, 0);
    wait_slow(35);
    rdr(6'h10, rd); check("R9 expiry flag", {31'b0, rd[3]}, 1);
    check("R12 rst high", {31'b0, rst_req}, 1);
    wait_slow(8);
    read_count(rd); check("R7 stays zero", rd, 0);

    // R10 R11 mask and clear
    wr(6'h14, 32'h1);
    check("R11 masked", {31'b0, irq}, {31'b0, exp_irq(1'b1, 1'b1, 1'b1)});
    wr(6'h14, 32'h0);
    check("R11 unmasked", {31'b0, irq}, 1);
    wr(6'h0C, 32'h0);
    rdr(6'h10, rd); check("R10 zero clear", rd & 32'h9, 32'h9);
    wr(6'h0C, 32'h8);
    rdr(6'h10, rd); check("R10 clear rst only", rd & 32'h9, 32'h1);
    check("R12 rst cleared", {31'b0, rst_req}, 0);
    wr(6'h0C, 32'h1);
    rdr(6'h10, rd); check("R10 clear irq", rd & 32'h9, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 0);

    // R8 R12 expiry-only interrupt mode, reset disabled
    wr(6'h08, 32'h0);
    load(32'd40, 32'd20);
    wait_slow(6);
    wr(6'h08, 32'h3);
    wait_slow(30);
    rdr(6'h10, rd); check("R8 mode0 no flag at warning", {31'b0, rd[0]}, 0);
    wait_slow(20);
    rdr(6'h10, rd); check("R8 mode0 flags at expiry", rd & 32'h9, 32'h9);
    check("R11 irq mode0", {31'b0, irq}, 1);
    check("R12 rst gated", {31'b0, rst_req}, 0);

    summary();
    $finish;
  end
endmodule